// File: doc/BRIEF.md
# Interrupt Vector Placement Register with Timed Unlock

This block is a byte-wide control register. It decides where the interrupt vector table lives: at address zero of program memory, or at the first address of the boot region. A second job is to hold the three external-interrupt enable bits. The vector select bit is protected against stray writes. Software must first set a change-enable bit. It then has a short window of cycles in which to write the new select value with change-enable cleared. A select write outside that window is dropped.

While the unlock sequence is in progress, the block masks interrupt acceptance through a dedicated suppress output. It never touches any interrupt-enable state. The same output also blocks interrupts when a lock input protects the region the core is executing from, and the vectors point to the other region. The core retires instructions through a strobe. The block uses that strobe to hold suppression until the instruction after the select write has completed.

Top module: `ivec_reloc_ctl`

## Requirements
- R1: `vec_base` is all zeros while the select bit (register bit 1) is 0. It equals `boot_base` while the select bit is 1.
- R2: The select bit takes the written bit 1 only when a write with bit 0 = 0 is captured while the unlock window is open. The window covers the four clock edges that follow the edge capturing a write with bit 0 = 1. A write on the fourth of those edges succeeds. A write on the fifth is ignored.
- R3: Change-enable (bit 0) reads 1 from the edge that captures it. It clears by itself on the fourth edge after that if no select write occurs. It clears immediately on the edge that captures a select write.
- R4: `irq_suppress` is high in the first cycle in which change-enable reads 1. If no select write follows, it stays high for exactly four cycles and then falls.
- R5: After a select write, `irq_suppress` stays high until the first clock edge at which `retire` is sampled high. The write's own edge does not count. It is low in the cycle after that edge.
- R6: Unlock suppression leaves the three enable bits untouched. Bit 7 is external interrupt 1, bit 6 is external interrupt 0 and bit 5 is external interrupt 2. These bits read back, and drive `ext_irq_en` as {bit5, bit7, bit6}, exactly as last written.
- R7: When the select bit is 1, `lock_app` is 1 and `exec_in_boot` is 0, `irq_suppress` is high.
- R8: When the select bit is 0, `lock_boot` is 1 and `exec_in_boot` is 1, `irq_suppress` is high. With no window, no hold and neither lock condition, it is low.
- R9: Every bit reads 0 after reset. Bits 4 to 2 always read 0.
- R10: A write that sets bit 1 while no window is open leaves the select bit unchanged. Bits 7 to 5 of the same write still update.
- R11: A write with bit 0 = 1 while a window is open restarts the countdown. The window then lasts four more edges from that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value |
| boot_base | input | ADDR_W | First address of the boot region |
| retire | input | 1 | Instruction-retire strobe from the core |
| lock_app | input | 1 | Lock protecting the application region |
| lock_boot | input | 1 | Lock protecting the boot region |
| exec_in_boot | input | 1 | 1 while the core executes from the boot region |
| vec_base | output | ADDR_W | Base address of the vector table |
| irq_suppress | output | 1 | Masks interrupt acceptance when high |
| ext_irq_en | output | 3 | External interrupt enables {int2, int1, int0} |

## Verification
All register results are due one edge after the write that causes them. The bench drives each input just after a falling edge and reads the outputs at the next falling edge, so each result is checked in the cycle it first becomes valid. The lock-gating path is combinational, so its checks are made within the same half cycle, after the inputs settle. Window timing is probed by counting idle cycles from the enable write, with the select write placed exactly on the fourth or fifth edge after it. Suppression is sampled in every cycle of the window, so both its length and its release are pinned down to the cycle.

// File: rtl/ivec_pkg.sv
package ivec_pkg;
  localparam int unsigned BIT_CE  = 0;
  localparam int unsigned BIT_SEL = 1;
  localparam int unsigned BIT_E2  = 5;
  localparam int unsigned BIT_E0  = 6;
  localparam int unsigned BIT_E1  = 7;

  // lock-based blocking: vectors in one region, execution in the other, lock on the executing side
  function automatic logic lock_gate_f(input logic sel, input logic lk_app,
                                       input logic lk_boot, input logic in_boot);
    return (sel && lk_app && !in_boot) || (!sel && lk_boot && in_boot);
  endfunction

  // ext_en order: [0]=int0, [1]=int1, [2]=int2
  function automatic logic [7:0] pack_reg_f(input logic [2:0] ext_en, input logic sel,
                                            input logic ce);
    logic [7:0] r;
    r = 8'h00;
    r[BIT_E0]  = ext_en[0];
    r[BIT_E1]  = ext_en[1];
    r[BIT_E2]  = ext_en[2];
    r[BIT_SEL] = sel;
    r[BIT_CE]  = ce;
    return r;
  endfunction
endpackage

// File: rtl/ivec_window.sv
module ivec_window #(
  parameter int unsigned WIN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic commit,
  input  logic retire,
  output logic win_open,
  output logic hold,
  output logic expire
);
  localparam int unsigned CW = (WIN > 1) ? $clog2(WIN) : 1;
  localparam logic [CW-1:0] START = CW'(WIN - 1);

  logic [CW-1:0] cnt_q;
  logic          open_q;
  logic          hold_q;

  assign expire = open_q && (cnt_q == '0) && !arm && !commit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else if (arm) begin
      open_q <= 1'b1;
      cnt_q  <= START;
    end else if (commit || expire) begin
      open_q <= 1'b0;
    end else if (open_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hold_q <= 1'b0;
    else if (commit) hold_q <= 1'b1;
    else if (retire) hold_q <= 1'b0;
  end

  assign win_open = open_q;
  assign hold     = hold_q;
endmodule

// File: rtl/ivec_gate.sv
module ivec_gate
  import ivec_pkg::*;
(
  input  logic sel,
  input  logic lock_app,
  input  logic lock_boot,
  input  logic exec_in_boot,
  input  logic win_open,
  input  logic hold,
  output logic lock_block,
  output logic suppress
);
  assign lock_block = lock_gate_f(sel, lock_app, lock_boot, exec_in_boot);
  assign suppress   = win_open || hold || lock_block;
endmodule

// File: rtl/ivec_reloc_ctl.sv
module ivec_reloc_ctl
  import ivec_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned WIN    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  input  logic [ADDR_W-1:0] boot_base,
  input  logic              retire,
  input  logic              lock_app,
  input  logic              lock_boot,
  input  logic              exec_in_boot,
  output logic [ADDR_W-1:0] vec_base,
  output logic              irq_suppress,
  output logic [2:0]        ext_irq_en
);
  logic       sel_q;
  logic [2:0] en_q;
  logic       win_open, hold, expire, lock_block;
  logic       arm, commit;

  assign arm    = wr_en && wr_data[BIT_CE];
  assign commit = wr_en && !wr_data[BIT_CE] && win_open;

  ivec_window #(.WIN(WIN)) u_win (
    .clk(clk), .rst_n(rst_n), .arm(arm), .commit(commit), .retire(retire),
    .win_open(win_open), .hold(hold), .expire(expire)
  );

  ivec_gate u_gate (
    .sel(sel_q), .lock_app(lock_app), .lock_boot(lock_boot),
    .exec_in_boot(exec_in_boot), .win_open(win_open), .hold(hold),
    .lock_block(lock_block), .suppress(irq_suppress)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      en_q  <= '0;
    end else if (wr_en) begin
      en_q <= {wr_data[BIT_E2], wr_data[BIT_E1], wr_data[BIT_E0]};
      if (commit) sel_q <= wr_data[BIT_SEL];
    end
  end

  assign vec_base   = sel_q ? boot_base : '0;
  assign rd_data    = pack_reg_f(en_q, sel_q, win_open);
  assign ext_irq_en = en_q;
endmodule

// File: rtl/ivec_reloc_chk.sv
module ivec_reloc_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned WIN    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              lock_app,
  input logic              exec_in_boot,
  input logic              arm,
  input logic              commit,
  input logic              win_open,
  input logic              hold,
  input logic              sel_q,
  input logic              irq_suppress,
  input logic [ADDR_W-1:0] vec_base,
  input logic [7:0]        rd_data
);
  logic [7:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_q <= '0;
    else if (arm)      run_q <= '0;
    else if (win_open) run_q <= run_q + 8'd1;
    else               run_q <= '0;
  end

  p_base_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_q |-> (vec_base == '0));
  p_sel_only_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(sel_q));
  p_window_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    win_open |-> (run_q < 8'(WIN)));
  p_arm_supp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (irq_suppress && rd_data[0]));
  p_commit_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (hold && irq_suppress && !rd_data[0]));
  p_lock_app_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q && lock_app && !exec_in_boot) |-> irq_suppress);
  p_reject_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !win_open) |=> $stable(sel_q));
endmodule

bind ivec_reloc_ctl ivec_reloc_chk #(.ADDR_W(ADDR_W), .WIN(WIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .lock_app(lock_app),
  .exec_in_boot(exec_in_boot), .arm(arm), .commit(commit), .win_open(win_open),
  .hold(hold), .sel_q(sel_q), .irq_suppress(irq_suppress), .vec_base(vec_base),
  .rd_data(rd_data)
);

// File: tb/sim_ivec_reloc_ctl.sv
module sim_ivec_reloc_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam logic [AW-1:0] BOOT = 16'h3800;

  logic clk = 0, rst_n = 0, wr_en = 0, retire = 0;
  logic lock_app = 0, lock_boot = 0, exec_in_boot = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic [AW-1:0] vec_base;
  logic irq_suppress;
  logic [2:0] ext_irq_en;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ivec_reloc_ctl #(.ADDR_W(AW), .WIN(4)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .boot_base(BOOT), .retire(retire), .lock_app(lock_app), .lock_boot(lock_boot),
    .exec_in_boot(exec_in_boot), .vec_base(vec_base), .irq_suppress(irq_suppress),
    .ext_irq_en(ext_irq_en)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // one cycle: drive after a falling edge, return at the next falling edge
  task automatic cyc(input logic we, input logic [7:0] d, input logic rt);
    wr_en = we; wr_data = d; retire = rt;
    @(negedge clk);
    wr_en = 0; wr_data = 0; retire = 0;
  endtask

  task automatic t_reset;
    chk("R9 reset read", rd_data, 8'h00);
    chk("R9 reset supp", irq_suppress, 0);
    chk("R1 reset base", vec_base, 0);
  endtask

  task automatic t_no_window;
    cyc(1, 8'hE2, 0);
    chk("R10 sel kept", rd_data[1], 0);
    chk("R10 enables written", rd_data, 8'hE0);
    chk("R6 ext_irq_en", ext_irq_en, 3'b111);
    chk("R1 base zero", vec_base, 0);
  endtask

  task automatic t_last_cycle;
    cyc(1, 8'hA1, 0);
    chk("R4 supp first", irq_suppress, 1);
    chk("R3 ce set", rd_data[0], 1);
    chk("R6 enables kept", rd_data[7:5], 3'b101);
    for (int i = 0; i < 3; i++) begin
      cyc(0, 0, 0);
      chk("R4 supp in window", irq_suppress, 1);
    end
    cyc(1, 8'h42, 1);                 // fourth edge after enable write
    chk("R2 sel set", rd_data, 8'h42);
    chk("R1 base boot", vec_base, BOOT);
    chk("R5 hold after write", irq_suppress, 1);
    cyc(0, 0, 0);
    chk("R5 hold no retire", irq_suppress, 1);
    cyc(0, 0, 1);
    chk("R5 released", irq_suppress, 0);
  endtask

  task automatic t_fifth_cycle;
    cyc(1, 8'h01, 0);
    for (int i = 0; i < 3; i++) begin
      cyc(0, 0, 0);
      chk("R4 supp held", irq_suppress, 1);
    end
    cyc(0, 0, 0);
    chk("R3 ce auto clear", rd_data[0], 0);
    chk("R4 supp four cycles", irq_suppress, 0);
    cyc(1, 8'h00, 0);                 // fifth edge: too late
    chk("R2 late write ignored", rd_data[1], 1);
    chk("R1 base stays", vec_base, BOOT);
  endtask

  task automatic t_rearm;
    cyc(1, 8'h01, 0);
    cyc(0, 0, 0);
    cyc(0, 0, 0);
    cyc(1, 8'h01, 0);                 // restart on third edge
    cyc(0, 0, 0);
    cyc(0, 0, 0);
    chk("R11 still open", rd_data[0], 1);
    cyc(0, 0, 0);
    cyc(1, 8'h00, 0);                 // fourth edge after re-arm
    chk("R11 late commit ok", rd_data[1], 0);
    chk("R3 ce cleared on write", rd_data[0], 0);
    cyc(0, 0, 1);
    chk("R5 released", irq_suppress, 0);
  endtask

  task automatic t_locks;
    logic s, e;
    for (int sv = 0; sv < 2; sv++) begin
      if (sv == 1) begin
        cyc(1, 8'h01, 0);
        cyc(1, 8'h02, 0);
        cyc(0, 0, 1);
      end
      for (int k = 0; k < 8; k++) begin
        lock_app = k[0]; lock_boot = k[1]; exec_in_boot = k[2];
        #1;
        s = sv[0];
        e = (s && k[0] && !k[2]) || (!s && k[1] && k[2]);
        chk(s ? "R7 lock gate" : "R8 lock gate", irq_suppress, e);
      end
      lock_app = 0; lock_boot = 0; exec_in_boot = 0;
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_no_window();
    t_last_cycle();
    t_fifth_cycle();
    t_rearm();
    t_locks();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule